// File: doc/BRIEF.md
# Bit-Sliced Configurable Logic Cluster

The cluster is a small programmable logic block for word-oriented arithmetic and data movement. It holds four identical subclusters, each one bit-slice of a datapath word. Every subcluster has four 4-input lookup tables. Each lookup-table input is fed through a fully populated local crossbar. The crossbar can pick any of the subcluster's ten input pins or the registered state of any of the sixteen lookup tables in the cluster. The pins come in three kinds. Two control pins are broadcast to all four slices. Three datapath groups each deliver one lane of a 4-lane bus to every slice, under one rotation setting that the group shares. Five regular pins are private to each slice.

Configuration enters serially, one bit per clock, while `cfg_en` is high. With `share_en` high, all four slices decode one common image and only that image, plus the datapath rotations, is shifted in. The chain is therefore much shorter. With `share_en` low, each slice has its own image, so irregular logic can be mapped. A three-state controller (EMPTY, LOAD, RUN) blanks the outputs until a load has completed, and again throughout any reload. It also clears the lookup-table flip-flops when a load ends.

Controller states and transitions: reset enters EMPTY. EMPTY goes to LOAD when `cfg_en` is high. LOAD stays in LOAD while `cfg_en` is high and goes to RUN when `cfg_en` is low. RUN stays in RUN while `cfg_en` is low and goes back to LOAD when `cfg_en` is high.

Top module: `bitslice_cluster`

## Requirements
- R1: While `rst` is high at a clock edge, the controller enters EMPTY, every configuration bit becomes 0 and every lookup-table flip-flop becomes 0. In EMPTY, `cluster_out` is all zero.
- R2: At every clock edge with `cfg_en` high, one bit from `cfg_din` enters configuration index 0 and every bit in the active chain moves up one index. With `share_en` low, the active chain is indices 0..597. With `share_en` high, it is indices 0..153, and indices 154..597 keep their values.
- R3: The configuration layout is as follows. Datapath group g's 2-bit rotation is at indices 2g..2g+1. Slice image s starts at index 6+148*s. Within an image, LUT l occupies 37 bits starting at 37*l: the truth table in bits 0..15, the select for LUT input k in bits 16+5k..20+5k, and the output-register bit in bit 36.
- R4: A LUT's combinational value is bit `{in3,in2,in1,in0}` of its truth table, with in0 as the least significant index bit.
- R5: The 5-bit crossbar select codes are as follows. Codes 0..1 pick control pins 0..1. Codes 2..4 pick datapath groups 0..2. Codes 5..9 pick the slice's regular pins 0..4. Codes 10..25 pick the flip-flop state of cluster LUT (code-10). Codes 26..31 give constant 0.
- R6: Control pin c (`ctrl_in[c]`) is the same signal in all four slices during the same cycle.
- R7: Datapath group g delivers `dp_in[4g + ((s + rot_g) mod 4)]` to slice s, where rot_g is that group's shared rotation.
- R8: With `share_en` high, every slice decodes image 0. With `share_en` low, slice s decodes image s. Images 1..3 kept from an earlier full load take effect again when `share_en` is lowered, without a reload.
- R9: Each LUT has a flip-flop that captures its combinational value at every RUN clock edge. The output-register bit selects whether the output shows that flip-flop (1) or the combinational value (0). Crossbar feedback always uses the flip-flop.
- R10: In the cycle after any clock edge where `cfg_en` was high, and for the rest of the load, `cluster_out` is all zero.
- R11: In the first RUN cycle after a load ends, every LUT flip-flop reads 0.
- R12: `cluster_out` bit 4*s+l carries LUT l of slice s while the controller is in RUN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_en | input | 1 | Shift one configuration bit per clock while high |
| cfg_din | input | 1 | Serial configuration data |
| share_en | input | 1 | All slices use image 0 and the chain shortens to 154 bits |
| ctrl_in | input | 2 | Broadcast control pins |
| dp_in | input | 12 | Datapath bus lanes, group g lane j at bit 4g+j |
| reg_in | input | 20 | Per-slice regular pins, slice s pin p at bit 5s+p |
| cluster_out | output | 16 | LUT results, bit 4*slice+LUT |

## Verification
A fully random per-slice image driven with random pins checks the select decoding, the truth-table indexing and the output order all at once. Any slip in field position or source code shows up as a mismatch within a few cycles. A directed image that routes control pins and rotated datapath lanes through buffer LUTs separates broadcast from lane rotation. A toggling registered LUT observed through a second slice's feedback path separates registered from combinational output and confirms the flip-flop clearing after a load. A shared-mode load followed by lowering `share_en` without a reload shows that the short chain left the other slices' images untouched.

// File: rtl/clb_pkg.sv
package clb_pkg;
    localparam int N_SUB     = 4;
    localparam int N_LUT     = 4;
    localparam int LUT_K     = 4;
    localparam int N_CTRL    = 2;
    localparam int N_DP      = 3;
    localparam int N_REG     = 5;
    localparam int N_PIN     = N_CTRL + N_DP + N_REG;
    localparam int N_OUT     = N_SUB * N_LUT;
    localparam int N_SRC     = N_PIN + N_OUT;
    localparam int SEL_W     = $clog2(N_SRC);
    localparam int TT_W      = 1 << LUT_K;
    localparam int LUT_CFG_W = TT_W + LUT_K * SEL_W + 1;
    localparam int IMG_W     = N_LUT * LUT_CFG_W;
    localparam int ROT_W     = $clog2(N_SUB);
    localparam int GLOB_W    = N_DP * ROT_W;
    localparam int LEN_SHARED = GLOB_W + IMG_W;
    localparam int LEN_FULL   = GLOB_W + N_SUB * IMG_W;

    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_LOAD  = 2'd1,
        ST_RUN   = 2'd2
    } clb_state_e;
endpackage

// File: rtl/clb_lut.sv
module clb_lut #(
    parameter int K = 4
) (
    input  logic [(1<<K)-1:0] truth_i,
    input  logic [K-1:0]      idx_i,
    output logic              val_o
);
    assign val_o = truth_i[idx_i];
endmodule

// File: rtl/clb_cfg_chain.sv
module clb_cfg_chain
    import clb_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_en,
    input  logic                cfg_din,
    input  logic                share_en,
    output logic [LEN_FULL-1:0] cfg_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (cfg_en) begin
            if (share_en) begin
                cfg_q[LEN_SHARED-1:0] <= {cfg_q[LEN_SHARED-2:0], cfg_din};
            end else begin
                cfg_q <= {cfg_q[LEN_FULL-2:0], cfg_din};
            end
        end
    end

    // R2
    shift_entry_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_en |=> (cfg_q[0] == $past(cfg_din)));

    // R2
    short_chain_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_en && share_en) |=> $stable(cfg_q[LEN_FULL-1:LEN_SHARED]));
endmodule

// File: rtl/clb_fsm.sv
module clb_fsm
    import clb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cfg_en,
    output logic run_o,
    output logic load_o
);
    clb_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_EMPTY;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: state_d = cfg_en ? ST_LOAD : ST_EMPTY;
            ST_LOAD:  state_d = cfg_en ? ST_LOAD : ST_RUN;
            ST_RUN:   state_d = cfg_en ? ST_LOAD : ST_RUN;
            default:  state_d = ST_EMPTY;
        endcase
    end

    always_comb begin
        run_o  = (state_q == ST_RUN);
        load_o = (state_q == ST_LOAD);
    end

    // R11
    run_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (load_o && !cfg_en) |=> run_o);

    // R10
    reload_entry_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_en |=> (load_o && !run_o));
endmodule

// File: rtl/clb_subcluster.sv
module clb_subcluster
    import clb_pkg::*;
(
    input  logic [N_PIN-1:0] pins_i,
    input  logic [N_OUT-1:0] fb_i,
    input  logic [IMG_W-1:0] img_i,
    output logic [N_LUT-1:0] comb_o,
    output logic [N_LUT-1:0] regsel_o
);
    localparam int SRC_PAD = 1 << SEL_W;

    logic [SRC_PAD-1:0] src;
    assign src = {{(SRC_PAD-N_SRC){1'b0}}, fb_i, pins_i};

    for (genvar l = 0; l < N_LUT; l++) begin : g_lut
        logic [LUT_CFG_W-1:0] lut_cfg;
        logic [LUT_K-1:0]     idx;
        assign lut_cfg = img_i[l*LUT_CFG_W +: LUT_CFG_W];
        for (genvar k = 0; k < LUT_K; k++) begin : g_in
            assign idx[k] = src[lut_cfg[TT_W + k*SEL_W +: SEL_W]];
        end
        clb_lut #(.K(LUT_K)) u_lut (
            .truth_i (lut_cfg[TT_W-1:0]),
            .idx_i   (idx),
            .val_o   (comb_o[l])
        );
        assign regsel_o[l] = lut_cfg[LUT_CFG_W-1];
    end
endmodule

// File: rtl/bitslice_cluster.sv
module bitslice_cluster
    import clb_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cfg_en,
    input  logic                    cfg_din,
    input  logic                    share_en,
    input  logic [N_CTRL-1:0]       ctrl_in,
    input  logic [N_DP*N_SUB-1:0]   dp_in,
    input  logic [N_REG*N_SUB-1:0]  reg_in,
    output logic [N_OUT-1:0]        cluster_out
);
    logic [LEN_FULL-1:0] cfg_q;
    logic                run, load;

    clb_cfg_chain u_chain (
        .clk      (clk),
        .rst      (rst),
        .cfg_en   (cfg_en),
        .cfg_din  (cfg_din),
        .share_en (share_en),
        .cfg_q    (cfg_q)
    );

    clb_fsm u_fsm (
        .clk    (clk),
        .rst    (rst),
        .cfg_en (cfg_en),
        .run_o  (run),
        .load_o (load)
    );

    logic [N_SUB-1:0][N_PIN-1:0] pins;

    always_comb begin
        int lane;
        for (int s = 0; s < N_SUB; s++) begin
            for (int c = 0; c < N_CTRL; c++) pins[s][c] = ctrl_in[c];
            for (int g = 0; g < N_DP; g++) begin
                lane = (s + int'(cfg_q[g*ROT_W +: ROT_W])) % N_SUB;
                pins[s][N_CTRL+g] = dp_in[g*N_SUB + lane];
            end
            for (int p = 0; p < N_REG; p++)
                pins[s][N_CTRL+N_DP+p] = reg_in[s*N_REG + p];
        end
    end

    logic [N_OUT-1:0] lut_comb, lut_regsel, lut_q;

    for (genvar s = 0; s < N_SUB; s++) begin : g_sub
        logic [IMG_W-1:0] img;
        assign img = share_en ? cfg_q[GLOB_W +: IMG_W]
                              : cfg_q[GLOB_W + s*IMG_W +: IMG_W];
        clb_subcluster u_sub (
            .pins_i   (pins[s]),
            .fb_i     (lut_q),
            .img_i    (img),
            .comb_o   (lut_comb[s*N_LUT +: N_LUT]),
            .regsel_o (lut_regsel[s*N_LUT +: N_LUT])
        );
    end

    always_ff @(posedge clk) begin
        if (rst || !run) lut_q <= '0;
        else             lut_q <= lut_comb;
    end

    always_comb begin
        for (int b = 0; b < N_OUT; b++)
            cluster_out[b] = run & (lut_regsel[b] ? lut_q[b] : lut_comb[b]);
    end

    // R11
    load_end_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (load && !cfg_en) |=> (lut_q == '0));

    // R10
    load_blank_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_en |=> (cluster_out == '0));

    // R9
    ff_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (run && !cfg_en) |=> (lut_q == $past(lut_comb)));
endmodule

// File: tb/bitslice_cluster_tb_top.sv
`timescale 1ns/1ps
module bitslice_cluster_tb_top;
    localparam int CLK_NS = 20;
    localparam int LFULL  = 598;
    localparam int LSH    = 154;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_en = 1'b0;
    logic        cfg_din = 1'b0;
    logic        share_en = 1'b0;
    logic [1:0]  ctrl_in = '0;
    logic [11:0] dp_in = '0;
    logic [19:0] reg_in = '0;
    logic [15:0] cluster_out;

    int checks = 0;
    int failures = 0;

    always #(CLK_NS/2) clk = ~clk;

    bitslice_cluster dut_i (
        .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_din(cfg_din),
        .share_en(share_en), .ctrl_in(ctrl_in), .dp_in(dp_in),
        .reg_in(reg_in), .cluster_out(cluster_out)
    );

    // reference model state
    bit [LFULL-1:0] mv;
    bit [LFULL-1:0] pend;
    bit [15:0]      mq, mcomb, mexp;
    int             mst;  // 0 empty, 1 load, 2 run

    function automatic bit src_val(int s, int sel);
        int g, rot;
        if (sel < 2)  return ctrl_in[sel];
        if (sel < 5) begin
            g = sel - 2;
            rot = int'(mv[2*g +: 2]);
            return dp_in[g*4 + ((s + rot) % 4)];
        end
        if (sel < 10) return reg_in[s*5 + sel - 5];
        if (sel < 26) return mq[sel - 10];
        return 1'b0;
    endfunction

    task automatic model_eval();
        for (int s = 0; s < 4; s++) begin
            int img = share_en ? 0 : s;
            for (int l = 0; l < 4; l++) begin
                int lb = 6 + img*148 + l*37;
                int idx = 0;
                for (int k = 0; k < 4; k++)
                    if (src_val(s, int'(mv[lb+16+5*k +: 5]))) idx += (1 << k);
                mcomb[s*4+l] = mv[lb+idx];
                mexp[s*4+l] = (mst == 2) ? (mv[lb+36] ? mq[s*4+l] : mcomb[s*4+l]) : 1'b0;
            end
        end
    endtask

    task automatic model_update();
        if (rst) begin
            mst = 0; mq = '0; mv = '0;
        end else begin
            mq = (mst == 2) ? mcomb : 16'h0;
            if (cfg_en) mst = 1;
            else if (mst == 1) begin
                mst = 2;
                if (share_en) mv[LSH-1:0] = pend[LSH-1:0];
                else          mv = pend;
            end
        end
    endtask

    task automatic tick(input string tag);
        #2;
        model_eval();
        checks++;
        if (cluster_out !== mexp) begin
            failures++;
            $display("FAIL %s: cluster_out=%h expected=%h at %0t", tag, cluster_out, mexp, $time);
        end
        @(posedge clk);
        model_update();
        @(negedge clk);
    endtask

    task automatic rand_pins();
        ctrl_in = 2'($urandom);
        dp_in   = 12'($urandom);
        reg_in  = 20'($urandom);
    endtask

    task automatic load_cfg(input bit [LFULL-1:0] v, input bit sh);
        int len = sh ? LSH : LFULL;
        share_en = sh;
        pend = v;
        for (int i = len - 1; i >= 0; i--) begin
            cfg_en = 1'b1;
            cfg_din = v[i];
            rand_pins();
            tick("R2/R10 load blanking");
        end
        cfg_en = 1'b0;
        cfg_din = 1'b0;
        tick("R10 last load cycle");
    endtask

    task automatic set_lut(inout bit [LFULL-1:0] v, input int s, input int l,
                           input bit [15:0] tt, input int s0, input int s1,
                           input int s2, input int s3, input bit rg);
        int lb = 6 + s*148 + l*37;
        v[lb +: 16] = tt;
        v[lb+16 +: 5] = 5'(s0);
        v[lb+21 +: 5] = 5'(s1);
        v[lb+26 +: 5] = 5'(s2);
        v[lb+31 +: 5] = 5'(s3);
        v[lb+36] = rg;
    endtask

    initial begin
        bit [LFULL-1:0] v;
        mv = '0; mq = '0; mst = 0; pend = '0;
        @(negedge clk);
        // R1: reset and idle EMPTY state
        for (int i = 0; i < 3; i++) begin rand_pins(); tick("R1 reset"); end
        rst = 1'b0;
        for (int i = 0; i < 4; i++) begin rand_pins(); tick("R1 empty"); end

        // R2 R3 R4 R5 R12: random independent images
        for (int i = 0; i < LFULL; i++) v[i] = 1'($urandom);
        load_cfg(v, 1'b0);
        for (int i = 0; i < 60; i++) begin rand_pins(); tick("R3/R4/R5/R12 random images"); end

        // R6 R7: broadcast and lane rotation
        v = '0;
        v[1:0] = 2'd1; v[3:2] = 2'd2; v[5:4] = 2'd3;
        for (int s = 0; s < 4; s++) begin
            set_lut(v, s, 0, 16'hAAAA, 0, 31, 31, 31, 1'b0);
            set_lut(v, s, 1, 16'hAAAA, 1, 31, 31, 31, 1'b0);
            set_lut(v, s, 2, 16'hAAAA, 2, 31, 31, 31, 1'b0);
            set_lut(v, s, 3, 16'h8888, 4, 3, 31, 31, 1'b0);
        end
        load_cfg(v, 1'b0);
        for (int i = 0; i < 20; i++) begin rand_pins(); tick("R6/R7 broadcast and rotation"); end

        // R9 R11: registered toggle seen through feedback
        v = '0;
        set_lut(v, 0, 0, 16'h5555, 10, 31, 31, 31, 1'b1);
        set_lut(v, 1, 2, 16'hAAAA, 10, 31, 31, 31, 1'b0);
        set_lut(v, 3, 3, 16'h5555, 30, 31, 31, 31, 1'b0);
        set_lut(v, 2, 1, 16'hAAAA, 5, 31, 31, 31, 1'b1);
        load_cfg(v, 1'b0);
        for (int i = 0; i < 12; i++) begin rand_pins(); tick("R9/R11 registered feedback"); end

        // R8: shared image, then retained images
        for (int i = 0; i < LSH; i++) v[i] = 1'($urandom);
        load_cfg(v, 1'b1);
        for (int i = 0; i < 30; i++) begin rand_pins(); tick("R8 shared image"); end
        share_en = 1'b0;
        for (int i = 0; i < 20; i++) begin rand_pins(); tick("R8 retained images"); end

        // R1: reset after running
        rst = 1'b1;
        tick("R1 reset after run");
        rst = 1'b0;
        for (int i = 0; i < 3; i++) begin rand_pins(); tick("R1 empty after reset"); end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(CLK_NS * 100000);
        checks++;
        failures++;
        $display("FAIL watchdog: run did not end, actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule